// File: doc/BRIEF.md
# Dual Audio Sample FIFO Controller

This block buffers stereo audio for playback. A host processor writes signed 8-bit samples into two FIFOs, one per channel, through a memory-mapped window. A one-cycle playback strobe removes one sample from each non-empty FIFO. Each removed sample is sign-extended and multiplied by 64, and the result drives that channel's output word. The left output comes from FIFO A and the right output from FIFO B.

The host keeps the FIFOs fed by watching a 4-bit sticky status register and a level interrupt. Status bits are set on exact occupancy transitions: half-empty, almost-empty and full. Reading the status register returns its value and then clears it along with the interrupt. A write to the mode register empties both FIFOs at once. A build-time variant selects a different flag rule: on every strobe, if FIFO A holds fewer than half its depth, the two upper status bits are raised.

Top module: `sfifo_stereo`

## Requirements
- R1: A write to an address in 0x000–0x3FF pushes its data byte into FIFO A, and a write in 0x400–0x7FF pushes into FIFO B, whatever the low address bits are. A write at 0x800 or above pushes into neither FIFO.
- R2: On each clock edge with `smp_tick` high, every FIFO that holds at least one byte gives up its oldest byte. That channel's output then becomes the byte sign-extended to 16 bits and shifted left by 6 (byte 0x80 gives 0xE000, 0x7F gives 0x1FC0).
- R3: A strobe that finds a FIFO empty leaves that channel's output word and occupancy unchanged.
- R4: Each FIFO stores at most 1023 bytes, and its pointers wrap modulo 1024, so byte order is kept across the wrap point.
- R5: When a write raises FIFO A to 1023 bytes, status bit 1 is set; bit 3 does the same for FIFO B. A write to a FIFO already holding 1023 bytes is dropped.
- R6: When a strobe drains FIFO A from 512 to 511 bytes, status bit 0 is set; bit 2 does the same for FIFO B.
- R7: When a strobe drains FIFO A from 2 to 1 byte, status bit 1 is set; bit 3 does the same for FIFO B.
- R8: The interrupt output is high from the cycle after any status bit is set. A read at address 0x804 returns the status on `bus_rdata` in bits 3:0 one cycle later, and clears the status and the interrupt.
- R9: A write to address 0x801, with any data, empties both FIFOs. A strobe that follows finds nothing to play.
- R10: With VARIANT=1, every strobe after which FIFO A holds fewer than 512 bytes sets bits 2 and 3 and the interrupt. The rules of R5–R7 are not used in this variant.
- R11: After reset, both outputs read 0, the interrupt is low and the status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Host write strobe |
| bus_rd_en | input | 1 | Host read strobe |
| bus_addr | input | 12 | Host byte address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data |
| smp_tick | input | 1 | One-cycle playback strobe |
| audio_l | output | 16 | Scaled left sample, from FIFO A |
| audio_r | output | 16 | Scaled right sample, from FIFO B |
| irq | output | 1 | Level interrupt |

## Verification
A host write is stored at the edge where `bus_wr_en` is sampled, so a strobe on the very next edge can already drain that byte. The output words, status bits and interrupt are registers that change at the edge carrying their cause. The bench reads them one time unit after that edge, or at the following falling edge. Read data appears on `bus_rdata` at the edge where `bus_rd_en` is sampled, and the bench reads it at the next falling edge. At that same falling edge the bench checks that the interrupt has already dropped. A scoreboard queue per channel predicts each strobe's output word: the sample at the head of the queue, or the previous word when the model queue is empty.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
   // status bit positions; the host decodes these
   localparam int ST_A_HALF = 0;
   localparam int ST_A_EDGE = 1;
   localparam int ST_B_HALF = 2;
   localparam int ST_B_EDGE = 3;
   localparam int ST_W      = 4;
   localparam int NUM_LANES = 2;

   typedef struct packed {
      logic half;
      logic empty;
      logic full;
   } lane_evt_t;
endpackage

// File: rtl/sfifo_decode.sv
module sfifo_decode #(
   parameter int ADDR_W   = 12,
   parameter int LOG2D    = 10,
   parameter int MODE_OFS = 12'h801,
   parameter int STAT_OFS = 12'h804
) (
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [1:0]        push_o,
   output logic              mode_wr_o,
   output logic              stat_rd_o
);
   localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_OFS);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

   logic in_window;

   always_comb begin
      in_window = (addr_i[ADDR_W-1:LOG2D+1] == '0);
      push_o[0] = wr_en_i && in_window && !addr_i[LOG2D];
      push_o[1] = wr_en_i && in_window &&  addr_i[LOG2D];
      mode_wr_o = wr_en_i && (addr_i == MODE_A);
      stat_rd_o = rd_en_i && (addr_i == STAT_A);
   end
endmodule

// File: rtl/sfifo_lane.sv
module sfifo_lane
   import sfifo_pkg::*;
#(
   parameter int DEPTH      = 1024,
   parameter int DATA_W     = 8,
   parameter int OUT_W      = 16,
   parameter int GAIN_SHIFT = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      push_i,
   input  logic [DATA_W-1:0]         wdata_i,
   input  logic                      pop_i,
   input  logic                      clr_i,
   output logic [$clog2(DEPTH)-1:0]  count_next_o,
   output logic [OUT_W-1:0]          sample_o,
   output lane_evt_t                 evt_o
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W;
   localparam logic [CNT_W-1:0] MAXC = CNT_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);
   localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  count_q, count_d;
   logic [OUT_W-1:0]  sample_q;
   logic [DATA_W-1:0] head;
   logic              push_ok, pop_ok;

   assign head    = mem[rd_ptr];
   assign push_ok = push_i && !clr_i && (count_q != MAXC);
   assign pop_ok  = pop_i  && !clr_i && (count_q != '0);

   always_comb begin
      count_d = count_q;
      if (clr_i)
         count_d = '0;
      else if (push_ok && !pop_ok)
         count_d = count_q + 1'b1;
      else if (pop_ok && !push_ok)
         count_d = count_q - 1'b1;
   end

   always_comb begin
      evt_o.half  = pop_ok  && !push_ok && (count_q == HALF);
      evt_o.empty = pop_ok  && !push_ok && (count_q == TWO);
      evt_o.full  = push_ok && !pop_ok  && (count_q == MAXC - 1'b1);
   end

   always_ff @(posedge clk) begin
      if (push_ok)
         mem[wr_ptr] <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         count_q  <= '0;
         sample_q <= '0;
      end else begin
         count_q <= count_d;
         if (clr_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
         end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok) begin
               rd_ptr   <= rd_ptr + 1'b1;
               sample_q <= {{(OUT_W-DATA_W){head[DATA_W-1]}}, head} << GAIN_SHIFT;
            end
         end
      end
   end

   assign count_next_o = count_d;
   assign sample_o     = sample_q;

   AST_DRAIN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i && !push_i && !clr_i && (count_q != '0) |=> count_q == $past(count_q) - 1'b1); // R2
   AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i && !push_i && !clr_i && (count_q == '0) |=> (count_q == '0) && $stable(sample_o)); // R3
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      push_i && !pop_i && !clr_i && (count_q == MAXC) |=> $stable(wr_ptr) && (count_q == MAXC)); // R5
   AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (count_q == '0) && (wr_ptr == rd_ptr)); // R9
endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags
   import sfifo_pkg::*;
#(
   parameter int VARIANT = 0,
   parameter int CNT_W   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lane_evt_t         evt_a_i,
   input  lane_evt_t         evt_b_i,
   input  logic              tick_i,
   input  logic              clr_i,
   input  logic [CNT_W-1:0]  cnt_a_next_i,
   input  logic              rd_i,
   output logic [ST_W-1:0]   status_o,
   output logic              irq_o
);
   localparam logic [CNT_W-1:0] HALF = CNT_W'(1 << (CNT_W - 1));

   logic [ST_W-1:0] set_vec;
   logic [ST_W-1:0] status_q;
   logic            irq_q;

   generate
      if (VARIANT == 0) begin : g_std
         always_comb begin
            set_vec             = '0;
            set_vec[ST_A_HALF]  = evt_a_i.half;
            set_vec[ST_A_EDGE]  = evt_a_i.empty | evt_a_i.full;
            set_vec[ST_B_HALF]  = evt_b_i.half;
            set_vec[ST_B_EDGE]  = evt_b_i.empty | evt_b_i.full;
         end
      end else begin : g_alt
         logic low_a;
         assign low_a = tick_i && !clr_i && (cnt_a_next_i < HALF);
         always_comb begin
            set_vec            = '0;
            set_vec[ST_B_HALF] = low_a;
            set_vec[ST_B_EDGE] = low_a;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         irq_q    <= 1'b0;
      end else if (rd_i) begin
         status_q <= set_vec;
         irq_q    <= |set_vec;
      end else begin
         status_q <= status_q | set_vec;
         irq_q    <= irq_q | (|set_vec);
      end
   end

   assign status_o = status_q;
   assign irq_o    = irq_q;

   AST_IRQ_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i && (set_vec != '0) |=> irq_o && ((status_o & $past(set_vec)) == $past(set_vec))); // R8
   AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i && (set_vec == '0) |=> (status_o == '0) && !irq_o); // R8
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> (status_o & $past(status_o)) == $past(status_o)); // R8
endmodule

// File: rtl/sfifo_stereo.sv
module sfifo_stereo
   import sfifo_pkg::*;
#(
   parameter int DEPTH      = 1024,
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 12,
   parameter int OUT_W      = 16,
   parameter int GAIN_SHIFT = 6,
   parameter int VARIANT    = 0,
   parameter int MODE_OFS   = 12'h801,
   parameter int STAT_OFS   = 12'h804
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic              bus_rd_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              smp_tick,
   output logic [OUT_W-1:0]  audio_l,
   output logic [OUT_W-1:0]  audio_r,
   output logic              irq
);
   localparam int LOG2D = $clog2(DEPTH);
   localparam int CNT_W = LOG2D;

   initial begin : elab_checks
      if ((1 << LOG2D) != DEPTH)
         $fatal(1, "DEPTH must be a power of two");
      if (ADDR_W < LOG2D + 2)
         $fatal(1, "ADDR_W too narrow for two FIFO windows");
      if (OUT_W < DATA_W + GAIN_SHIFT)
         $fatal(1, "OUT_W cannot hold the scaled sample");
      if (DATA_W < ST_W)
         $fatal(1, "DATA_W narrower than status");
      if (VARIANT != 0 && VARIANT != 1)
         $fatal(1, "VARIANT must be 0 or 1");
   end

   logic [1:0]       push;
   logic             mode_wr, stat_rd;
   logic [CNT_W-1:0] cnt_next [NUM_LANES];
   logic [OUT_W-1:0] smp      [NUM_LANES];
   lane_evt_t        evt      [NUM_LANES];
   logic [ST_W-1:0]  status;
   logic [DATA_W-1:0] rdata_q;

   sfifo_decode #(
      .ADDR_W(ADDR_W), .LOG2D(LOG2D), .MODE_OFS(MODE_OFS), .STAT_OFS(STAT_OFS)
   ) u_decode (
      .wr_en_i(bus_wr_en), .rd_en_i(bus_rd_en), .addr_i(bus_addr),
      .push_o(push), .mode_wr_o(mode_wr), .stat_rd_o(stat_rd)
   );

   generate
      for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
         sfifo_lane #(
            .DEPTH(DEPTH), .DATA_W(DATA_W), .OUT_W(OUT_W), .GAIN_SHIFT(GAIN_SHIFT)
         ) u_lane (
            .clk(clk), .rst_n(rst_n),
            .push_i(push[i]), .wdata_i(bus_wdata),
            .pop_i(smp_tick), .clr_i(mode_wr),
            .count_next_o(cnt_next[i]), .sample_o(smp[i]), .evt_o(evt[i])
         );
      end
   endgenerate

   sfifo_flags #(.VARIANT(VARIANT), .CNT_W(CNT_W)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .evt_a_i(evt[0]), .evt_b_i(evt[1]),
      .tick_i(smp_tick), .clr_i(mode_wr), .cnt_a_next_i(cnt_next[0]),
      .rd_i(stat_rd), .status_o(status), .irq_o(irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (bus_rd_en)
         rdata_q <= stat_rd ? DATA_W'(status) : '0;
   end

   assign bus_rdata = rdata_q;
   assign audio_l   = smp[0];
   assign audio_r   = smp[1];

   AST_RDATA_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd |=> bus_rdata == DATA_W'($past(status))); // R8
   AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (status != '0) |-> irq); // R8
endmodule

// File: tb/tb_sfifo_stereo.sv
module tb_sfifo_stereo;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 0, rd = 0, tick = 0;
   logic [11:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [15:0] out_l, out_r;
   logic        irq;

   logic        x_wr = 0, x_rd = 0, x_tick = 0;
   logic [11:0] x_addr = '0;
   logic [7:0]  x_wdata = '0;
   logic [7:0]  x_rdata;
   logic [15:0] x_l, x_r;
   logic        x_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [7:0] qa[$];
   logic [7:0] qb[$];
   logic [7:0] last_a = 8'h00;
   logic [7:0] last_b = 8'h00;

   always #(CLK_PERIOD/2) clk = ~clk;

   sfifo_stereo dut (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(wr), .bus_rd_en(rd),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
      .smp_tick(tick), .audio_l(out_l), .audio_r(out_r), .irq(irq)
   );

   sfifo_stereo #(.VARIANT(1)) dut_alt (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(x_wr), .bus_rd_en(x_rd),
      .bus_addr(x_addr), .bus_wdata(x_wdata), .bus_rdata(x_rdata),
      .smp_tick(x_tick), .audio_l(x_l), .audio_r(x_r), .irq(x_irq)
   );

   function automatic logic [15:0] scl(input logic [7:0] b);
      return {{8{b[7]}}, b} << 6;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // driver: pushes expected bytes into the scoreboard
   task automatic host_wr(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      wr = 1; addr = a; wdata = d;
      @(negedge clk);
      wr = 0;
      if (a < 12'h400) begin
         if (qa.size() < 1023) qa.push_back(d);
      end else if (a < 12'h800) begin
         if (qb.size() < 1023) qb.push_back(d);
      end else if (a == 12'h801) begin
         qa.delete(); qb.delete();
      end
   endtask

   task automatic host_rd(output logic [7:0] v);
      @(negedge clk);
      rd = 1; addr = 12'h804;
      @(negedge clk);
      rd = 0;
      v = rdata;
   endtask

   task automatic play(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); tick = 1;
         @(negedge clk); tick = 0;
      end
   endtask

   task automatic alt_wr(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk); x_wr = 1; x_addr = a; x_wdata = d;
      @(negedge clk); x_wr = 0;
   endtask

   task automatic alt_rd(output logic [7:0] v);
      @(negedge clk); x_rd = 1; x_addr = 12'h804;
      @(negedge clk); x_rd = 0;
      v = x_rdata;
   endtask

   task automatic alt_play(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); x_tick = 1;
         @(negedge clk); x_tick = 0;
      end
   endtask

   // monitor: pops the scoreboard on every strobe and compares
   always @(posedge clk) begin
      if (rst_n && tick) begin
         #1;
         if (qa.size() > 0) begin
            last_a = qa.pop_front();
            chk("R2 left sample", {16'h0, out_l}, {16'h0, scl(last_a)});
         end else
            chk("R3 left hold", {16'h0, out_l}, {16'h0, scl(last_a)});
         if (qb.size() > 0) begin
            last_b = qb.pop_front();
            chk("R2 right sample", {16'h0, out_r}, {16'h0, scl(last_b)});
         end else
            chk("R3 right hold", {16'h0, out_r}, {16'h0, scl(last_b)});
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] v;
      logic [7:0] last_full;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R11 reset state
      chk("R11 left", {16'h0, out_l}, 32'h0);
      chk("R11 right", {16'h0, out_r}, 32'h0);
      chk("R11 irq", {31'h0, irq}, 32'h0);
      host_rd(v);
      chk("R11 status", {24'h0, v}, 32'h0);

      // R1 window decode, R2 scaling, R7 almost-empty
      host_wr(12'h000, 8'h11);
      host_wr(12'h3FF, 8'h80);
      host_wr(12'h123, 8'h7F);
      host_wr(12'h200, 8'hFF);
      host_wr(12'h010, 8'h05);
      host_wr(12'h400, 8'h22);
      host_wr(12'h7FF, 8'h81);
      host_wr(12'h555, 8'h01);
      host_wr(12'h900, 8'h99);   // R1: control area, no push
      chk("R8 irq idle", {31'h0, irq}, 32'h0);
      play(6);
      chk("R8 irq raised", {31'h0, irq}, 32'h1);
      host_rd(v);
      chk("R7 empty bits", {24'h0, v}, 32'h0A);
      chk("R8 irq cleared", {31'h0, irq}, 32'h0);
      host_rd(v);
      chk("R8 status cleared", {24'h0, v}, 32'h0);

      // R6 half-empty on both lanes
      host_wr(12'h801, 8'h00);
      for (int i = 0; i < 513; i++) host_wr(12'(i % 1024), 8'(i));
      for (int i = 0; i < 513; i++) host_wr(12'h400 + 12'(i % 1024), 8'(i * 3));
      play(2);
      host_rd(v);
      chk("R6 half bits", {24'h0, v}, 32'h05);

      // R5 full flag and dropped write, R4 wrap
      host_wr(12'h801, 8'h00);   // R9 clear
      for (int i = 0; i < 1023; i++) host_wr(12'(i % 1024), 8'(i * 7 + 3));
      chk("R5 irq on full", {31'h0, irq}, 32'h1);
      host_rd(v);
      chk("R5 full bit", {24'h0, v}, 32'h02);
      last_full = 8'(1022 * 7 + 3);
      host_wr(12'h0AA, 8'hEE);   // dropped
      play(1025);
      chk("R5 dropped write absent", {16'h0, out_l}, {16'h0, scl(last_full)});
      host_wr(12'h001, 8'hA1);
      host_wr(12'h002, 8'hB2);
      host_wr(12'h003, 8'hC3);
      play(3);
      chk("R4 wrap order", {16'h0, out_l}, {16'h0, scl(8'hC3)});
      host_rd(v);
      chk("R6 R7 after drain", {24'h0, v}, 32'h03);

      // R9 mode write empties both FIFOs
      host_wr(12'h011, 8'h5A);
      host_wr(12'h012, 8'h6B);
      host_wr(12'h444, 8'h77);
      host_wr(12'h801, 8'h3C);
      play(1);
      chk("R9 left nothing played", {16'h0, out_l}, {16'h0, scl(8'hC3)});
      host_wr(12'h020, 8'h3C);
      play(1);
      chk("R9 refill plays", {16'h0, out_l}, {16'h0, scl(8'h3C)});

      // R10 alternate variant
      alt_wr(12'h000, 8'h10);
      alt_wr(12'h001, 8'h20);
      alt_wr(12'h002, 8'h30);
      alt_play(1);
      chk("R10 alt irq", {31'h0, x_irq}, 32'h1);
      alt_rd(v);
      chk("R10 alt low bits", {24'h0, v}, 32'h0C);
      alt_play(1);
      alt_rd(v);
      chk("R10 alt no empty bit", {24'h0, v}, 32'h0C);
      for (int i = 0; i < 514; i++) alt_wr(12'(i % 1024), 8'(i));
      alt_play(1);
      alt_rd(v);
      chk("R10 alt above half", {24'h0, v}, 32'h00);
      chk("R10 alt irq low", {31'h0, x_irq}, 32'h0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule